// File: doc/BRIEF.md
# Black-Level Clamp Feedback Controller

This block closes the digital half of an optical-black clamp loop for a line-scanned image sensor. It watches a 10-bit ADC sample stream together with a once-per-line marker pulse. Inside a fixed window that follows each marker it sums eight black-level samples. It takes either that line's mean or a mean over the last four lines and subtracts it from a programmable clamp code. The signed difference is sent out once per line as a correction word for the current DAC that charges the black-level hold capacitor.

After a change of the amplifier gain, the loop has to settle quickly. A one-cycle strobe arms a fast lead-in mode, which starts at the next line. In that mode the correction is multiplied by a selectable power of two. The mode stays on while the measured error is large. Once the error is small it lasts for a selectable number of further lines and then drops back to unity gain. A status pin shows when lead-in is active.

The sample input has no handshake. The ADC delivers one sample on every clock and cannot be stalled, so the block takes `adc_data` on every rising edge. The correction output is a one-cycle `corr_valid` pulse with no ready. The consumer must capture it in that cycle, and `corr_data` holds its value until the next line's result.

Top module: `blkc_ctrl`

## Requirements
- R1: The clamp target is 2·`clamp_sel`+14 (14 to 76). Outside lead-in, `corr_data` equals target minus the measured black level, as a signed two's-complement value.
- R2: The marker is active when `obp` XOR `obp_inv` is 1, so `obp_inv`=1 selects an active-low marker. The first rising clock edge that samples it active is edge 0. It is accepted only if it is still active at edge 2. A pulse of 1 or 2 clocks produces no output and no state change.
- R3: The samples taken at edges 5 through 12 form the window. With `avg4_en`=0 the measured level is their sum shifted right by 3.
- R4: With `avg4_en`=1 the measured level is the sum of this window and the three previous window sums, shifted right by 5. Window sums are recorded on every accepted line, whatever `avg4_en` is.
- R5: `corr_data` changes and `corr_valid` is high for exactly one clock after edge 13. `corr_valid` is never high at any other time.
- R6: A `gain_chg` pulse, including one that arrives inside a window, is held pending. It sets `boost_active` at edge 2 of the next accepted line. That line's own correction is already boosted.
- R7: During lead-in the error is shifted left by `boost_sel`+2. The codes are 0→×4, 1→×8, 2→×16, 3→×32, with `boost_sel` read as an unsigned number.
- R8: A boosted line with |error| > 32 restarts the hold count. A boosted line with |error| ≤ 32 adds one to it. When the count reaches 2^`hold_sel` lines (1, 2, 4 or 8), `boost_active` clears at that line's edge 13.
- R9: A synchronous reset clears `corr_data`, `corr_valid`, `boost_active`, the pending strobe, the hold count and the three stored window sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_data | input | 10 | ADC sample, taken every clock |
| obp | input | 1 | Line marker pulse |
| obp_inv | input | 1 | Marker polarity: 1 = active low |
| clamp_sel | input | 5 | Clamp code setting |
| boost_sel | input | 2 | Lead-in gain multiplier code |
| hold_sel | input | 2 | Lead-in hold length code |
| avg4_en | input | 1 | 1 = four-line averaging |
| gain_chg | input | 1 | One-cycle gain-changed strobe |
| corr_data | output | 16 | Signed correction word |
| corr_valid | output | 1 | One-cycle strobe for a new correction |
| boost_active | output | 1 | Fast lead-in active |

## Verification
Every result is timed from the first edge that sees the marker active. The correction and its strobe are due just after edge 13. A lead-in entry is visible just after edge 2 of the following line, and a lead-in exit is visible together with the correction of the line that finishes the hold. The bench drives every input on falling edges and keeps a per-line offset counter. It reads the correction on the falling edge after edge 13 and the lead-in flag on the falling edge after edge 2. On every other falling edge it confirms that the strobe is low.

// File: rtl/blkc_pkg.sv
package blkc_pkg;
  localparam int ADC_W     = 10;  // sample width
  localparam int CLAMP_W   = 5;   // clamp code width
  localparam int CORR_W    = 16;  // correction word width
  localparam int WIN_FIRST = 5;   // first window edge after marker
  localparam int WIN_LEN   = 8;   // samples per window
  localparam int MIN_PULSE = 3;   // marker edges needed to accept
  localparam int AVG_LINES = 4;   // lines in the long average
  localparam int LEAD_THR  = 32;  // lead-in error threshold
  localparam int TGT_BASE  = 14;  // clamp code offset

  typedef enum logic [1:0] {
    MULT_X4  = 2'd0,
    MULT_X8  = 2'd1,
    MULT_X16 = 2'd2,
    MULT_X32 = 2'd3
  } mult_code_e;
endpackage

// File: rtl/blkc_obp_win.sv
module blkc_obp_win #(
  parameter int ADC_W     = blkc_pkg::ADC_W,
  parameter int WIN_FIRST = blkc_pkg::WIN_FIRST,
  parameter int WIN_LEN   = blkc_pkg::WIN_LEN,
  parameter int MIN_PULSE = blkc_pkg::MIN_PULSE,
  localparam int SUM_W    = ADC_W + $clog2(WIN_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             obp,
  input  logic             obp_inv,
  input  logic [ADC_W-1:0] adc_data,
  output logic             line_start,
  output logic             win_done,
  output logic [SUM_W-1:0] win_sum
);
  localparam int WIN_LAST = WIN_FIRST + WIN_LEN - 1;
  localparam int POS_W    = $clog2(WIN_LAST + 2);
  localparam int RUN_W    = $clog2(MIN_PULSE + 1);

  logic             act;
  logic [RUN_W-1:0] run;
  logic [POS_W-1:0] pos;
  logic             busy;
  logic [SUM_W-1:0] acc;
  logic             in_win;

  assign act        = obp ^ obp_inv;
  assign line_start = act && !busy && (run == RUN_W'(MIN_PULSE - 1));
  assign in_win     = (pos >= POS_W'(WIN_FIRST)) && (pos <= POS_W'(WIN_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= '0;
      pos      <= '0;
      busy     <= 1'b0;
      acc      <= '0;
      win_done <= 1'b0;
      win_sum  <= '0;
    end else begin
      win_done <= 1'b0;
      if (!act)                            run <= '0;
      else if (run != RUN_W'(MIN_PULSE))   run <= run + 1'b1;
      if (line_start) begin
        busy <= 1'b1;
        pos  <= POS_W'(MIN_PULSE);
        acc  <= '0;
      end else if (busy) begin
        pos <= pos + 1'b1;
        if (in_win) acc <= acc + SUM_W'(adc_data);
        if (pos == POS_W'(WIN_LAST)) begin
          busy     <= 1'b0;
          win_done <= 1'b1;
          win_sum  <= acc + SUM_W'(adc_data);
        end
      end
    end
  end

  // R2: a line is accepted only after three consecutive active marker samples
  a_r2_marker_qualified: assert property (@(posedge clk) disable iff (rst)
    line_start |-> act && $past(act) && $past(act, 2));

  // R5: a finished window is reported for one cycle only
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    win_done |=> !win_done);
endmodule

// File: rtl/blkc_avg.sv
module blkc_avg #(
  parameter int ADC_W     = blkc_pkg::ADC_W,
  parameter int WIN_LEN   = blkc_pkg::WIN_LEN,
  parameter int AVG_LINES = blkc_pkg::AVG_LINES,
  localparam int SUM_W    = ADC_W + $clog2(WIN_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_done,
  input  logic [SUM_W-1:0] win_sum,
  input  logic             avg4_en,
  output logic [ADC_W-1:0] avg_val
);
  localparam int LWIN   = $clog2(WIN_LEN);
  localparam int LAVG   = $clog2(AVG_LINES);
  localparam int TOT_W  = SUM_W + LAVG;
  localparam int HIST_N = AVG_LINES - 1;

  logic [SUM_W-1:0] hist [HIST_N];
  logic [TOT_W-1:0] tot;

  always_comb begin
    tot = TOT_W'(win_sum);
    for (int k = 0; k < HIST_N; k++) tot = tot + TOT_W'(hist[k]);
  end

  assign avg_val = avg4_en ? ADC_W'(tot >> (LWIN + LAVG)) : ADC_W'(win_sum >> LWIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < HIST_N; k++) hist[k] <= '0;
    end else if (win_done) begin
      hist[0] <= win_sum;
      for (int k = 1; k < HIST_N; k++) hist[k] <= hist[k-1];
    end
  end

  // R4: the newest window sum enters the history after each line
  a_r4_hist_load: assert property (@(posedge clk) disable iff (rst)
    win_done |=> hist[0] == $past(win_sum));
endmodule

// File: rtl/blkc_lead.sv
module blkc_lead #(
  parameter int ADC_W    = blkc_pkg::ADC_W,
  parameter int CLAMP_W  = blkc_pkg::CLAMP_W,
  parameter int CORR_W   = blkc_pkg::CORR_W,
  parameter int LEAD_THR = blkc_pkg::LEAD_THR,
  parameter int TGT_BASE = blkc_pkg::TGT_BASE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              gain_chg,
  input  logic              win_done,
  input  logic [ADC_W-1:0]  avg_val,
  input  logic [CLAMP_W-1:0] clamp_sel,
  input  logic [1:0]        boost_sel,
  input  logic [1:0]        hold_sel,
  output logic [CORR_W-1:0] corr_data,
  output logic              corr_valid,
  output logic              boost
);
  localparam int ERR_W  = ADC_W + 1;
  localparam int SH_MAX = 5;
  localparam int WIDE_W = ERR_W + SH_MAX;
  localparam int CALC_W = ((WIDE_W > CORR_W) ? WIDE_W : CORR_W) + 1;
  localparam int HCNT_W = 4;
  localparam logic signed [CALC_W-1:0] SAT_HI = CALC_W'((64'sd1 <<< (CORR_W - 1)) - 64'sd1);
  localparam logic signed [CALC_W-1:0] SAT_LO = -SAT_HI - CALC_W'(1);

  logic [ERR_W-1:0]         tgt_u;
  logic signed [ERR_W-1:0]  err;
  logic signed [ERR_W-1:0]  thr;
  logic                     big;
  logic [2:0]               shamt;
  logic signed [CALC_W-1:0] wide;
  logic [CORR_W-1:0]        corr_next;
  logic [HCNT_W-1:0]        hcnt;
  logic [HCNT_W-1:0]        hold_len;
  logic                     pend;

  assign tgt_u    = ERR_W'({clamp_sel, 1'b0}) + ERR_W'(TGT_BASE);
  assign err      = $signed(tgt_u) - $signed({1'b0, avg_val});
  assign thr      = ERR_W'(LEAD_THR);
  assign big      = (err > thr) || (err < -thr);
  assign shamt    = boost ? (3'(boost_sel) + 3'd2) : 3'd0;
  assign hold_len = HCNT_W'(1) << hold_sel;

  always_comb begin
    wide = CALC_W'(err) <<< shamt;
    if (wide > SAT_HI)      corr_next = CORR_W'(SAT_HI);
    else if (wide < SAT_LO) corr_next = CORR_W'(SAT_LO);
    else                    corr_next = CORR_W'(wide);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      corr_data  <= '0;
      corr_valid <= 1'b0;
      boost      <= 1'b0;
      hcnt       <= '0;
      pend       <= 1'b0;
    end else begin
      corr_valid <= 1'b0;
      if (gain_chg) pend <= 1'b1;
      if (line_start && (pend || gain_chg)) begin
        boost <= 1'b1;
        hcnt  <= '0;
        pend  <= 1'b0;
      end
      if (win_done) begin
        corr_data  <= corr_next;
        corr_valid <= 1'b1;
        if (boost) begin
          if (big) begin
            hcnt <= '0;
          end else if (hcnt + 1'b1 == hold_len) begin
            boost <= 1'b0;
            hcnt  <= '0;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
      end
    end
  end

  // R5: the correction strobe lasts one clock
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    corr_valid |=> !corr_valid);

  // R6: lead-in only begins at an accepted line start
  a_r6_boost_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(boost) |-> $past(line_start));

  // R8: lead-in only ends together with a line result
  a_r8_boost_exit: assert property (@(posedge clk) disable iff (rst)
    $fell(boost) |-> $past(win_done) && corr_valid);

  // R8: the hold count never reaches the longest hold length
  a_r8_hold_bound: assert property (@(posedge clk) disable iff (rst)
    hcnt < HCNT_W'(8));
endmodule

// File: rtl/blkc_ctrl.sv
module blkc_ctrl #(
  parameter int ADC_W   = blkc_pkg::ADC_W,
  parameter int CLAMP_W = blkc_pkg::CLAMP_W,
  parameter int CORR_W  = blkc_pkg::CORR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADC_W-1:0]   adc_data,
  input  logic               obp,
  input  logic               obp_inv,
  input  logic [CLAMP_W-1:0] clamp_sel,
  input  logic [1:0]         boost_sel,
  input  logic [1:0]         hold_sel,
  input  logic               avg4_en,
  input  logic               gain_chg,
  output logic [CORR_W-1:0]  corr_data,
  output logic               corr_valid,
  output logic               boost_active
);
  localparam int SUM_W = ADC_W + $clog2(blkc_pkg::WIN_LEN);

  logic             line_start;
  logic             win_done;
  logic [SUM_W-1:0] win_sum;
  logic [ADC_W-1:0] avg_val;

  blkc_obp_win #(.ADC_W(ADC_W)) u_win (
    .clk        (clk),
    .rst        (rst),
    .obp        (obp),
    .obp_inv    (obp_inv),
    .adc_data   (adc_data),
    .line_start (line_start),
    .win_done   (win_done),
    .win_sum    (win_sum)
  );

  blkc_avg #(.ADC_W(ADC_W)) u_avg (
    .clk      (clk),
    .rst      (rst),
    .win_done (win_done),
    .win_sum  (win_sum),
    .avg4_en  (avg4_en),
    .avg_val  (avg_val)
  );

  blkc_lead #(.ADC_W(ADC_W), .CLAMP_W(CLAMP_W), .CORR_W(CORR_W)) u_lead (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .gain_chg   (gain_chg),
    .win_done   (win_done),
    .avg_val    (avg_val),
    .clamp_sel  (clamp_sel),
    .boost_sel  (boost_sel),
    .hold_sel   (hold_sel),
    .corr_data  (corr_data),
    .corr_valid (corr_valid),
    .boost      (boost_active)
  );
endmodule

// File: tb/blkc_ctrl_bench.sv
`timescale 1ns/1ps
module blkc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [9:0]  adc_data;
  logic        obp, obp_inv;
  logic [4:0]  clamp_sel;
  logic [1:0]  boost_sel, hold_sel;
  logic        avg4_en, gain_chg;
  logic [15:0] corr_data;
  logic        corr_valid, boost_active;

  int checks = 0;
  int errors = 0;

  // reference model state
  int h0, h1, h2;
  bit m_boost, m_pend;
  int m_hcnt;

  always #2.5 clk = ~clk;

  blkc_ctrl u_blkc_ctrl (
    .clk(clk), .rst(rst), .adc_data(adc_data), .obp(obp), .obp_inv(obp_inv),
    .clamp_sel(clamp_sel), .boost_sel(boost_sel), .hold_sel(hold_sel),
    .avg4_en(avg4_en), .gain_chg(gain_chg), .corr_data(corr_data),
    .corr_valid(corr_valid), .boost_active(boost_active)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int sat16(int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; gain_chg = 1'b0; obp = obp_inv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    h0 = 0; h1 = 0; h2 = 0; m_boost = 0; m_pend = 0; m_hcnt = 0;
    @(negedge clk);
    // R9: outputs cleared by reset
    chk(corr_valid == 1'b0, "R9 valid after reset", int'(corr_valid), 0);
    chk(corr_data == 16'd0, "R9 data after reset", int'($signed(corr_data)), 0);
    chk(boost_active == 1'b0, "R9 lead-in after reset", int'(boost_active), 0);
  endtask

  // One 20-clock line. Window values are v + random(0..spread).
  task automatic line(int plen, bit inv, int cs, int bs, int hs, bit a4,
                      int gchg_at, int v, int spread, string tag);
    int win[8];
    int sum, avg, err, exp_corr, start_boost, stray;
    bit accepted;
    sum = 0; stray = 0;
    for (int k = 0; k < 8; k++) begin
      win[k] = v + ((spread > 0) ? int'($urandom % (spread + 1)) : 0);
      if (win[k] > 1023) win[k] = 1023;
      sum += win[k];
    end
    accepted = (plen >= 3);
    exp_corr = 0;
    if (accepted) begin
      if (m_pend) begin m_boost = 1; m_hcnt = 0; m_pend = 0; end
      start_boost = int'(m_boost);
      avg = a4 ? ((sum + h0 + h1 + h2) >> 5) : (sum >> 3);
      err = (2 * cs + 14) - avg;
      exp_corr = sat16(m_boost ? err * (1 << (bs + 2)) : err);
      h2 = h1; h1 = h0; h0 = sum;
      if (m_boost) begin
        if (err > 32 || err < -32) m_hcnt = 0;
        else if (m_hcnt + 1 == (1 << hs)) begin m_boost = 0; m_hcnt = 0; end
        else m_hcnt++;
      end
    end else begin
      start_boost = int'(m_boost);
    end
    if (gchg_at >= 0) m_pend = 1;

    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      // outputs here reflect clock edge i-1 of this line
      if (i == 14 && accepted) begin
        chk(corr_valid == 1'b1, {tag, " R5 strobe at edge 13"}, int'(corr_valid), 1);
        chk(int'($signed(corr_data)) == exp_corr, {tag, " correction"},
            int'($signed(corr_data)), exp_corr);
        chk(int'(boost_active) == int'(m_boost), {tag, " R8 lead-in after line"},
            int'(boost_active), int'(m_boost));
      end else if (i > 0 && corr_valid) begin
        stray++;
      end
      if (i == 3 && accepted)
        chk(int'(boost_active) == start_boost, {tag, " R6 lead-in at line start"},
            int'(boost_active), start_boost);
      if (i == 0) begin
        obp_inv = inv; clamp_sel = 5'(cs); boost_sel = 2'(bs);
        hold_sel = 2'(hs); avg4_en = a4;
      end
      obp      = (i < plen) ? ~inv : inv;
      adc_data = (i >= 5 && i <= 12) ? 10'(win[i-5]) : 10'($urandom % 1024);
      gain_chg = (i == gchg_at);
    end
    chk(stray == 0, {tag, " R5/R2 no stray strobe"}, stray, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    void'($urandom(32'd7741));
    rst = 1'b1; adc_data = '0; obp_inv = 1'b0; obp = 1'b0; clamp_sel = 5'd9;
    boost_sel = 2'd0; hold_sel = 2'd0; avg4_en = 1'b0; gain_chg = 1'b0;
    do_reset();

    // R1/R3: default clamp 32, window mean near target
    line(4, 0, 9, 0, 0, 0, -1, 30, 7, "R1/R3 basic");
    line(6, 0, 9, 0, 0, 0, -1, 200, 40, "R1/R3 high black");
    // R2: active-low marker accepted, short pulses ignored
    line(5, 1, 9, 0, 0, 0, -1, 20, 15, "R2 inverted");
    line(2, 0, 9, 0, 0, 0, -1, 500, 0, "R2 short pulse");
    line(2, 1, 9, 0, 0, 0, -1, 500, 0, "R2 short inverted");
    line(3, 0, 9, 0, 0, 0, -1, 0, 0, "R2 minimum pulse");
    // R1: clamp code extremes
    line(4, 0, 0, 0, 0, 0, -1, 14, 0, "R1 clamp min");
    line(4, 0, 31, 0, 0, 0, -1, 0, 0, "R1 clamp max");
    line(4, 0, 31, 0, 0, 0, -1, 1023, 0, "R1 full scale");
    // R4: four-line average
    line(4, 0, 9, 0, 0, 1, -1, 100, 30, "R4 avg4 a");
    line(4, 0, 9, 0, 0, 1, -1, 40, 3, "R4 avg4 b");
    // R6/R7/R8: strobe inside a window, then lead-in with hold of 4 lines
    line(4, 0, 9, 1, 2, 0, 8, 60, 0, "R6 strobe in window");
    line(4, 0, 9, 1, 2, 0, -1, 132, 0, "R7 x8 large error");
    line(4, 0, 9, 1, 2, 0, -1, 65, 0, "R8 error -33");
    line(4, 0, 9, 1, 2, 0, -1, 64, 0, "R8 error -32 h1");
    line(4, 0, 9, 1, 2, 0, -1, 0, 0, "R8 error 32 h2");
    line(4, 0, 9, 1, 2, 0, -1, 40, 0, "R8 small h3");
    line(4, 0, 9, 1, 2, 0, -1, 33, 0, "R8 small h4");
    line(4, 0, 9, 1, 2, 0, -1, 33, 0, "R8 back to normal");
    // R7: each multiplier, hold of one line
    for (int b = 0; b < 4; b++) begin
      line(4, 0, 9, b, 0, 0, 16, 30, 0, "R6 strobe between");
      line(4, 0, 9, b, 0, 0, -1, 1000, 0, "R7 multiplier large");
      line(4, 0, 9, b, 0, 0, -1, 20, 0, "R7 multiplier exit");
    end
    // R9: reset mid lead-in clears history and state
    line(4, 0, 9, 3, 3, 0, 8, 900, 0, "R9 arm");
    line(4, 0, 9, 3, 3, 0, -1, 900, 0, "R9 boosted");
    do_reset();
    line(4, 0, 9, 0, 0, 1, -1, 400, 0, "R9 R4 history cleared");

    // random mix
    for (int n = 0; n < 48; n++) begin
      line(1 + int'($urandom % 8), 1'($urandom), int'($urandom % 32),
           int'($urandom % 4), int'($urandom % 4), 1'($urandom),
           (($urandom % 4) == 0) ? 8 : -1, int'($urandom % 1024),
           int'($urandom % 64), "random R1 R3 R7 R8");
    end
    report();
  end
endmodule